// File: doc/BRIEF.md
# Software-Filled Lockable Translation Buffer

This block is a fully associative address translation cache whose contents are placed entirely by software. A driver writes a tag word and a translation word into two staging registers, chooses a replacement slot through a lock register, and fires a load command that copies the staging pair into that slot. Translation requests present a 32-bit virtual address; one cycle later the block returns a hit flag, the physical address and three page attributes (byte order, element width, mixed-width flag). Four page sizes are supported: 4 KB, 64 KB, 1 MB and 16 MB.

Slots below a software-set base index are considered locked: the replacement pointer can never be placed below that base. Each entry carries a keep flag that protects it from the whole-table invalidate, while the targeted single-entry invalidate removes matching entries whether they carry the keep flag or not. A lookup that finds no entry sets a sticky fault flag, records the missing address and, when enabled, asserts the interrupt line.

Table updates are sequenced by a small command state machine with four states: `OP_IDLE` (no table update pending), `OP_LOAD` (copy staging pair into the victim slot), `OP_FLUSH_ONE` (invalidate entries matching the staged tag and size) and `OP_FLUSH_ALL` (invalidate all entries without the keep flag). A register write of a command moves the machine from any state into the matching command state on the next edge; every command state performs its update in that cycle and returns to `OP_IDLE` unless another command write arrives in the same cycle, in which case it goes directly to the new command state.

Top module: `swl_tlb`

## Requirements
- R1: The tag staging register at offset 0x18 keeps the virtual tag in bits [31:12], the size code in bits [1:0] (0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 16 MB), valid in bit 2 and keep in bit 3; the translation staging register at offset 0x1C keeps the physical base in bits [31:12], byte order in bit 9, element width in bits [8:7] and mixed-width in bit 6. Every other bit of both reads back as 0.
- R2: Writing a word with bit 0 set to offset 0x14 copies both staging registers into the slot named by the victim pointer; lookups sampled from the second clock edge after the write see the new entry.
- R3: A request sampled at a clock edge produces `resp_valid` after that edge; on a hit the physical address takes the entry's base bits above the page boundary and the request's bits below it, and the attributes come from the same entry.
- R4: Tag comparison uses only the virtual bits above the page boundary of each entry's own size: [31:12], [31:16], [31:20] or [31:24].
- R5: When several valid entries match, the one with the lowest slot index supplies the result.
- R6: The lock register at offset 0x10 holds the lock base in bits [20:16] and the victim pointer in bits [4:0]; a written victim below the written base is stored as the base.
- R7: Writing a word with bit 0 set to offset 0x20 invalidates every valid entry whose size code equals the staged size code and whose tag matches the staged tag over that size's bits, including entries with the keep flag; other entries are untouched.
- R8: Any write to offset 0x60 invalidates every entry whose keep flag is 0 and leaves entries with the keep flag valid.
- R9: A lookup without a hit returns `resp_hit` = 0; from the next edge the fault status bit (bit 0 of offset 0x04) is 1 and offset 0x0C holds the missing virtual address.
- R10: Writing 1 to bit 0 of offset 0x04 clears the fault status; a miss reported in the same cycle as that write leaves the status set.
- R11: `irq` is 1 exactly when the fault status bit and the enable bit (bit 0 of offset 0x08, read/write) are both 1.
- R12: A lookup sampled at the same edge as a table update sees the table contents from before that update.
- R13: After reset every entry is invalid and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Translation result present |
| resp_hit | output | 1 | Result found an entry |
| resp_pa | output | 32 | Translated physical address |
| resp_endian | output | 1 | Byte-order attribute of the hit entry |
| resp_elsize | output | 2 | Element-width attribute of the hit entry |
| resp_mixed | output | 1 | Mixed-width attribute of the hit entry |
| irq | output | 1 | Fault interrupt |

## Verification
Two pairs of functions can land on the same clock edge: a lookup miss raising the fault status together with a software write that clears it, and a lookup together with the table update performed by the command state machine. The bench provokes the first by issuing a missing request and driving the clear write in the very next cycle, expecting the status to remain set; it provokes the second by issuing a request for a new entry's address in the cycle right after the load command write, expecting a miss, then a hit on the following request. Constrained random traffic over a small tag pool repeats both kinds of overlap with overlapping sizes, locked slots and mixed invalidates, all judged against a bench-side table model.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

    localparam int TAG_W = 20;

    typedef struct packed {
        logic             valid;
        logic             keep;
        logic [1:0]       psz;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] pbase;
        logic             endian;
        logic [1:0]       elsz;
        logic             mixed;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_LOAD,
        OP_FLUSH_ONE,
        OP_FLUSH_ALL
    } tlb_op_e;

    localparam logic [7:0] OFS_STAT   = 8'h04;
    localparam logic [7:0] OFS_IEN    = 8'h08;
    localparam logic [7:0] OFS_FAULT  = 8'h0C;
    localparam logic [7:0] OFS_LOCK   = 8'h10;
    localparam logic [7:0] OFS_LOAD   = 8'h14;
    localparam logic [7:0] OFS_CAM    = 8'h18;
    localparam logic [7:0] OFS_RAM    = 8'h1C;
    localparam logic [7:0] OFS_FLUSH  = 8'h20;
    localparam logic [7:0] OFS_GFLUSH = 8'h60;

    localparam logic [31:0] CAM_KEEP_MASK = 32'hFFFF_F00F;
    localparam logic [31:0] RAM_KEEP_MASK = 32'hFFFF_F3C0;
    localparam int          LOCK_BASE_LSB = 16;

    // Bits of the 20-bit tag that take part in matching, per size code.
    function automatic logic [TAG_W-1:0] size_mask(input logic [1:0] code);
        logic [TAG_W-1:0] m;
        unique case (code)
            2'd0:    m = 20'hFFF00;
            2'd1:    m = 20'hFFFF0;
            2'd2:    m = 20'hFFFFF;
            default: m = 20'hFF000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlb_regs.sv
module tlb_regs
    import swtlb_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [7:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic                     miss_evt,
    input  logic [31:0]              miss_va,
    output logic [31:0]              cam_q,
    output logic [31:0]              ram_q,
    output logic [$clog2(N_ENT)-1:0] victim,
    output logic                     op_load,
    output logic                     op_flush1,
    output logic                     op_flushall,
    output logic                     irq
);

    localparam int IDX_W = $clog2(N_ENT);

    tlb_op_e          state_q, state_d;
    logic [IDX_W-1:0] base_q, vic_q;
    logic             stat_q, ien_q;
    logic [31:0]      fault_q;
    logic [IDX_W-1:0] wr_base, wr_vic;
    logic             clr_hit;

    assign wr_base = reg_wdata[LOCK_BASE_LSB +: IDX_W];
    assign wr_vic  = reg_wdata[IDX_W-1:0];
    assign clr_hit = reg_we && (reg_addr == OFS_STAT) && reg_wdata[0];

    // Command decode: next state of the update sequencer.
    always_comb begin
        state_d = OP_IDLE;
        if (reg_we) begin
            case (reg_addr)
                OFS_LOAD:   if (reg_wdata[0]) state_d = OP_LOAD;
                OFS_FLUSH:  if (reg_wdata[0]) state_d = OP_FLUSH_ONE;
                OFS_GFLUSH: state_d = OP_FLUSH_ALL;
                default:    state_d = OP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OP_IDLE;
        else        state_q <= state_d;
    end

    // Output process of the sequencer.
    always_comb begin
        op_load     = 1'b0;
        op_flush1   = 1'b0;
        op_flushall = 1'b0;
        unique case (state_q)
            OP_IDLE:      ;
            OP_LOAD:      op_load     = 1'b1;
            OP_FLUSH_ONE: op_flush1   = 1'b1;
            OP_FLUSH_ALL: op_flushall = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cam_q   <= '0;
            ram_q   <= '0;
            base_q  <= '0;
            vic_q   <= '0;
            stat_q  <= 1'b0;
            ien_q   <= 1'b0;
            fault_q <= '0;
        end else begin
            if (reg_we && reg_addr == OFS_CAM) cam_q <= reg_wdata & CAM_KEEP_MASK;
            if (reg_we && reg_addr == OFS_RAM) ram_q <= reg_wdata & RAM_KEEP_MASK;
            if (reg_we && reg_addr == OFS_IEN) ien_q <= reg_wdata[0];
            if (reg_we && reg_addr == OFS_LOCK) begin
                base_q <= wr_base;
                vic_q  <= (wr_vic < wr_base) ? wr_base : wr_vic;
            end
            if (miss_evt) begin
                stat_q  <= 1'b1;
                fault_q <= miss_va;
            end else if (clr_hit) begin
                stat_q  <= 1'b0;
            end
        end
    end

    assign victim = vic_q;
    assign irq    = stat_q & ien_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STAT:  reg_rdata[0] = stat_q;
            OFS_IEN:   reg_rdata[0] = ien_q;
            OFS_FAULT: reg_rdata    = fault_q;
            OFS_LOCK: begin
                reg_rdata[LOCK_BASE_LSB +: IDX_W] = base_q;
                reg_rdata[IDX_W-1:0]              = vic_q;
            end
            OFS_CAM:   reg_rdata    = cam_q;
            OFS_RAM:   reg_rdata    = ram_q;
            default:   reg_rdata    = '0;
        endcase
    end

    assert_victim_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vic_q >= base_q);

    assert_miss_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_evt |=> (stat_q && fault_q == $past(miss_va)));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !miss_evt) |=> !stat_q);

endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import swtlb_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_load,
    input  logic                     op_flush1,
    input  logic                     op_flushall,
    input  logic [31:0]              cam_q,
    input  logic [31:0]              ram_q,
    input  logic [$clog2(N_ENT)-1:0] victim,
    input  logic                     req_valid,
    input  logic [31:0]              req_va,
    output logic                     resp_valid,
    output logic                     resp_hit,
    output logic [31:0]              resp_pa,
    output logic                     resp_endian,
    output logic [1:0]               resp_elsize,
    output logic                     resp_mixed,
    output logic [31:0]              resp_va
);

    localparam int IDX_W = $clog2(N_ENT);

    tlb_ent_t         ent_q [N_ENT];
    tlb_ent_t         new_ent, sel_ent;
    logic [N_ENT-1:0] hit_vec, fl_vec, loose_vec;
    logic [TAG_W-1:0] va_tag, cam_tag, sel_mask;
    logic [IDX_W-1:0] sel;
    logic             any_hit;

    assign va_tag  = req_va[31:12];
    assign cam_tag = cam_q[31:12];

    assign new_ent = '{valid: cam_q[2], keep: cam_q[3], psz: cam_q[1:0], tag: cam_tag,
                       pbase: ram_q[31:12], endian: ram_q[9], elsz: ram_q[8:7],
                       mixed: ram_q[6]};

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g]   = ent_q[g].valid &&
                              (((ent_q[g].tag ^ va_tag) & size_mask(ent_q[g].psz)) == '0);
        assign fl_vec[g]    = ent_q[g].valid && (ent_q[g].psz == cam_q[1:0]) &&
                              (((ent_q[g].tag ^ cam_tag) & size_mask(ent_q[g].psz)) == '0);
        assign loose_vec[g] = ent_q[g].valid && !ent_q[g].keep;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (op_load && victim == IDX_W'(i)) begin
                ent_q[i] <= new_ent;
            end else if (op_flushall && !ent_q[i].keep) begin
                ent_q[i].valid <= 1'b0;
            end else if (op_flush1 && fl_vec[i]) begin
                ent_q[i].valid <= 1'b0;
            end
        end
    end

    // Lowest matching slot wins.
    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel     = IDX_W'(i);
                any_hit = 1'b1;
            end
        end
    end

    assign sel_ent  = ent_q[sel];
    assign sel_mask = size_mask(sel_ent.psz);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_pa     <= '0;
            resp_endian <= 1'b0;
            resp_elsize <= '0;
            resp_mixed  <= 1'b0;
            resp_va     <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_hit    <= any_hit;
                resp_va     <= req_va;
                resp_pa     <= any_hit ? {(sel_ent.pbase & sel_mask) | (va_tag & ~sel_mask),
                                          req_va[11:0]} : '0;
                resp_endian <= any_hit & sel_ent.endian;
                resp_elsize <= any_hit ? sel_ent.elsz : 2'b00;
                resp_mixed  <= any_hit & sel_ent.mixed;
            end
        end
    end

    assert_load_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_load |=> (ent_q[$past(victim)].tag == $past(cam_tag)));

    assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    assert_global_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_flushall && !op_load) |=> (loose_vec == '0));

endmodule

// File: rtl/swl_tlb.sv
module swl_tlb
    import swtlb_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    output logic        resp_valid,
    output logic        resp_hit,
    output logic [31:0] resp_pa,
    output logic        resp_endian,
    output logic [1:0]  resp_elsize,
    output logic        resp_mixed,
    output logic        irq
);

    localparam int IDX_W = $clog2(N_ENT);

    logic [31:0]      cam_q, ram_q, resp_va;
    logic [IDX_W-1:0] victim;
    logic             op_load, op_flush1, op_flushall, miss_evt;

    assign miss_evt = resp_valid & ~resp_hit;

    tlb_regs #(.N_ENT(N_ENT)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .miss_evt    (miss_evt),
        .miss_va     (resp_va),
        .cam_q       (cam_q),
        .ram_q       (ram_q),
        .victim      (victim),
        .op_load     (op_load),
        .op_flush1   (op_flush1),
        .op_flushall (op_flushall),
        .irq         (irq)
    );

    tlb_array #(.N_ENT(N_ENT)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_load     (op_load),
        .op_flush1   (op_flush1),
        .op_flushall (op_flushall),
        .cam_q       (cam_q),
        .ram_q       (ram_q),
        .victim      (victim),
        .req_valid   (req_valid),
        .req_va      (req_va),
        .resp_valid  (resp_valid),
        .resp_hit    (resp_hit),
        .resp_pa     (resp_pa),
        .resp_endian (resp_endian),
        .resp_elsize (resp_elsize),
        .resp_mixed  (resp_mixed),
        .resp_va     (resp_va)
    );

endmodule

// File: tb/swl_tlb_bench.sv
`timescale 1ns/1ps
module swl_tlb_bench;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        resp_valid, resp_hit, resp_endian, resp_mixed, irq;
    logic [31:0] resp_pa;
    logic [1:0]  resp_elsize;

    int n_chk = 0;
    int n_fail = 0;

    // Bench-side table model.
    logic        b_valid [N];
    logic        b_keep  [N];
    logic [1:0]  b_psz   [N];
    logic [19:0] b_tag   [N];
    logic [19:0] b_pb    [N];
    logic        b_en    [N];
    logic [1:0]  b_es    [N];
    logic        b_mx    [N];
    logic        m_stat = 1'b0;
    logic        m_ien = 1'b0;
    int          m_base = 0;

    always #10 clk = ~clk;

    swl_tlb u_swl_tlb (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_va(req_va), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_pa(resp_pa), .resp_endian(resp_endian), .resp_elsize(resp_elsize),
        .resp_mixed(resp_mixed), .irq(irq)
    );

    function automatic logic [19:0] bmask(input logic [1:0] c);
        case (c)
            2'd0: return 20'hFFF00;
            2'd1: return 20'hFFFF0;
            2'd2: return 20'hFFFFF;
            default: return 20'hFF000;
        endcase
    endfunction

    function automatic int model_find(input logic [31:0] va);
        for (int i = 0; i < N; i++)
            if (b_valid[i] && (((b_tag[i] ^ va[31:12]) & bmask(b_psz[i])) == 20'h0))
                return i;
        return -1;
    endfunction

    function automatic logic [31:0] model_pa(input int i, input logic [31:0] va);
        logic [19:0] m;
        m = bmask(b_psz[i]);
        return {(b_pb[i] & m) | (va[31:12] & ~m), va[11:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_stat();
        wr(8'h04, 32'h1);
        m_stat = 1'b0;
    endtask

    task automatic load_entry(input int idx, input logic [19:0] tag, input logic [1:0] psz,
                              input logic keep, input logic [19:0] pb, input logic en,
                              input logic [1:0] es, input logic mx);
        wr(8'h10, (32'(m_base) << 16) | 32'(idx));
        wr(8'h18, {tag, 8'h00, keep, 1'b1, psz});
        wr(8'h1C, {pb, 2'b00, en, es, mx, 6'h00});
        wr(8'h14, 32'h1);
        @(negedge clk);
        b_valid[idx] = 1'b1; b_keep[idx] = keep; b_psz[idx] = psz; b_tag[idx] = tag;
        b_pb[idx] = pb; b_en[idx] = en; b_es[idx] = es; b_mx[idx] = mx;
    endtask

    task automatic flush_one(input logic [19:0] tag, input logic [1:0] psz);
        wr(8'h18, {tag, 8'h00, 2'b00, psz});
        wr(8'h20, 32'h1);
        @(negedge clk);
        for (int i = 0; i < N; i++)
            if (b_valid[i] && b_psz[i] == psz && (((b_tag[i] ^ tag) & bmask(psz)) == 20'h0))
                b_valid[i] = 1'b0;
    endtask

    task automatic flush_all();
        wr(8'h60, 32'h0);
        @(negedge clk);
        for (int i = 0; i < N; i++) if (!b_keep[i]) b_valid[i] = 1'b0;
    endtask

    task automatic lookup_chk(input string req, input logic [31:0] va);
        int          k;
        logic [31:0] d;
        k = model_find(va);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " resp_valid"}, {31'b0, resp_valid}, 32'h1);
        check({req, " hit"}, {31'b0, resp_hit}, {31'b0, k >= 0});
        if (k >= 0) begin
            check({req, " pa"}, resp_pa, model_pa(k, va));
            check({req, " attrs"}, {28'h0, resp_endian, resp_elsize, resp_mixed},
                  {28'h0, b_en[k], b_es[k], b_mx[k]});
        end else begin
            m_stat = 1'b1;
        end
        @(negedge clk);
        rd(8'h04, d);
        check("R9 status", d, {31'b0, m_stat});
        if (k < 0) begin
            rd(8'h0C, d);
            check("R9 fault address", d, va);
        end
        check("R11 irq", {31'b0, irq}, {31'b0, m_stat & m_ien});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < N; i++) b_valid[i] = 1'b0;
        for (int i = 0; i < N; i++) b_keep[i] = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        rd(8'h04, d); check("R13 status", d, 32'h0);
        rd(8'h10, d); check("R13 lock", d, 32'h0);
        rd(8'h08, d); check("R13 enable", d, 32'h0);
        rd(8'h18, d); check("R13 tag staging", d, 32'h0);
        check("R13 irq", {31'b0, irq}, 32'h0);
        check("R13 resp_valid", {31'b0, resp_valid}, 32'h0);
        lookup_chk("R13 empty table", 32'h0000_1000);
        clear_stat();

        // R1 staging formats
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d); check("R1 tag staging", d, 32'hFFFF_F00F);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); check("R1 xlat staging", d, 32'hFFFF_F3C0);

        // R6 victim floor
        wr(8'h10, 32'h0004_0002); rd(8'h10, d); check("R6 clamp", d, 32'h0004_0004);
        wr(8'h10, 32'h0004_0009); rd(8'h10, d); check("R6 above base", d, 32'h0004_0009);
        m_base = 4;

        // R2 R3 R4: one entry per page size
        load_entry(4, 20'h12345, 2'd2, 1'b1, 20'h80000, 1'b1, 2'd3, 1'b0);
        load_entry(5, 20'h22220, 2'd1, 1'b0, 20'h90010, 1'b0, 2'd1, 1'b1);
        load_entry(6, 20'h33300, 2'd0, 1'b1, 20'hA0000, 1'b1, 2'd2, 1'b1);
        load_entry(7, 20'h44000, 2'd3, 1'b0, 20'hB1234, 1'b0, 2'd0, 1'b0);
        lookup_chk("R2 R3 small", 32'h1234_5ABC);
        check("R3 small pa", resp_pa, 32'h8000_0ABC);
        lookup_chk("R4 large", 32'h2222_F123);
        check("R4 large pa", resp_pa, 32'h9001_F123);
        lookup_chk("R4 section", 32'h333A_BCDE);
        check("R4 section pa", resp_pa, 32'hA00A_BCDE);
        lookup_chk("R4 super", 32'h44FF_FFFF);
        check("R4 super pa", resp_pa, 32'hB1FF_FFFF);
        lookup_chk("R4 small neighbour miss", 32'h1234_6000);

        // R11 enable
        check("R11 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h1); m_ien = 1'b1;
        check("R11 irq enabled", {31'b0, irq}, 32'h1);
        clear_stat();
        check("R10 clear", {31'b0, irq}, 32'h0);

        // R5 lowest index wins
        load_entry(8, 20'h12345, 2'd2, 1'b0, 20'hC0000, 1'b0, 2'd0, 1'b0);
        lookup_chk("R5 priority", 32'h1234_5010);
        check("R5 priority pa", resp_pa, 32'h8000_0010);

        // R7 targeted invalidate removes kept entries too
        flush_one(20'h12345, 2'd2);
        lookup_chk("R7 flushed", 32'h1234_5010);
        lookup_chk("R7 other kept", 32'h2222_0000);
        clear_stat();

        // R8 whole-table invalidate
        flush_all();
        lookup_chk("R8 kept entry", 32'h3330_0004);
        lookup_chk("R8 large gone", 32'h2222_0000);
        lookup_chk("R8 super gone", 32'h4400_0000);

        // R10 collision: miss and clear in the same cycle
        req_valid = 1'b1; req_va = 32'h5555_5000;
        @(negedge clk);
        req_valid = 1'b0;
        reg_we = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(8'h04, d); check("R10 set wins", d, 32'h1);
        rd(8'h0C, d); check("R9 collision fault", d, 32'h5555_5000);
        clear_stat();
        rd(8'h04, d); check("R10 cleared", d, 32'h0);

        // R12 lookup in the cycle of the table update sees old contents
        wr(8'h10, 32'h0004_000A);
        wr(8'h18, {20'h66666, 8'h00, 4'b0110});
        wr(8'h1C, {20'h70707, 12'h000});
        wr(8'h14, 32'h1);
        req_valid = 1'b1; req_va = 32'h6666_6123;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 old contents", {31'b0, resp_hit}, 32'h0);
        m_stat = 1'b1;
        b_valid[10] = 1'b1; b_keep[10] = 1'b0; b_psz[10] = 2'd2; b_tag[10] = 20'h66666;
        b_pb[10] = 20'h70707; b_en[10] = 1'b0; b_es[10] = 2'd0; b_mx[10] = 1'b0;
        @(negedge clk);
        lookup_chk("R12 new contents", 32'h6666_6123);
        clear_stat();

        // Constrained random traffic
        for (int it = 0; it < 400; it++) begin
            logic [19:0] t;
            int          op;
            t  = {8'hA0 + 8'($urandom % 3), 4'($urandom % 3), 8'($urandom % 4)};
            op = int'($urandom % 8);
            if (op < 3) begin
                load_entry(m_base + int'($urandom % (N - m_base)), t, 2'($urandom),
                           1'($urandom), 20'($urandom), 1'($urandom), 2'($urandom),
                           1'($urandom));
            end else if (op < 6) begin
                lookup_chk("R3 R4 R5 random", {t, 12'($urandom)});
            end else if (op == 6) begin
                if ($urandom % 4 == 0) flush_all();
                else flush_one(t, 2'($urandom));
            end else begin
                clear_stat();
                rd(8'h04, d); check("R10 random clear", d, 32'h0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule